// File: doc/BRIEF.md
# Multiplexed External Bus Bridge

This block connects an 8-bit CPU core to a package with few pins. One shared 8-bit pad group carries the whole 16-bit address and the 8-bit data path. An off-chip controller picks what the pads carry through a 2-bit phase code. It steps through all four phases inside each CPU cycle, so the CPU never waits. The phase code first passes through a two-flop synchronizer. Only then does it steer the pad drivers.

The bridge also decodes every CPU address. A small on-chip window at 0xA000–0xA047 holds the peripherals. An access to that window raises one peripheral select and is kept off the external bus: no external write occurs, and the pad value is ignored on reads. All other addresses go out through the pads. The read byte taken from the pads is registered. That register keeps its value until the next read-data phase.

Top module: `mux_bus_bridge`

## Requirements
- R1: With the synchronized phase at 01, the pads are driven (`pad_oe`=1) with address bits [15:8].
- R2: With the synchronized phase at 00, the pads are driven with address bits [7:0].
- R3: With the synchronized phase at 10, `pad_oe` is 0. The pad byte present at that clock edge is loaded into the read register, which keeps its value in every other phase. After reset the register holds 0x00.
- R4: With the synchronized phase at 11, the pads carry `cpu_wdata`. `pad_oe` is 1 only for a write to an external address. For a read, or for any access to the internal window, `pad_oe` is 0.
- R5: `ext_rnw` is 1 for a read and 0 for a write. For any access to the internal window it is held at 1.
- R6: `ext_cycle` is 0 for addresses 0xA000 through 0xA047 inclusive, and 1 for every other address.
- R7: `per_sel` bit 0 covers 0xA000–0xA00B, bit 1 covers 0xA020–0xA027, bit 2 covers 0xA030–0xA033, and bit 3 covers 0xA040–0xA047. Outside these ranges no bit is set, and that includes the reserved range 0xA010–0xA017.
- R8: `cpu_rdata` returns the selected peripheral's byte for an access inside the window. Peripheral n's byte is `per_rdata[8n+7:8n]`. The reserved range and any unassigned window address return 0x00, whatever is on the pads. For an external address, `cpu_rdata` returns the read register.
- R9: `per_wr` is 1 only for a write with a peripheral select set. A write to the reserved range raises neither `per_wr` nor `ext_cycle`.
- R10: A change on `phase_sel` reaches the pad controls two clock edges later. The pads do not change after only one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rnw | input | 1 | CPU direction, 1 = read |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| phase_sel | input | 2 | Phase code from the off-chip controller |
| pad_in | input | 8 | Value sensed on the shared pads |
| pad_out | output | 8 | Value driven on the shared pads |
| pad_oe | output | 1 | Pad output enable |
| ext_rnw | output | 1 | Direction exported off chip, 1 = read |
| ext_cycle | output | 1 | Current access targets external memory |
| per_sel | output | 4 | One-hot peripheral selects |
| per_wr | output | 1 | Peripheral write strobe |
| per_rdata | input | 32 | Packed read bytes of the four peripherals |

## Verification
Two functions can overlap in one cycle. The pad capture of phase 10 can happen while the CPU addresses the internal window, and the write-data phase 11 can come during an internal write. The bench mixes window-boundary addresses, reserved and unassigned addresses with all four phase codes and arbitrary pad bytes. In each such cycle it judges that `cpu_rdata` shows the peripheral byte or 0x00, not the pad byte, and that the pads stay undriven in phase 11. It also confirms that a later external read returns the byte captured earlier.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int N_PER  = 4;

    typedef enum logic [1:0] {
        PH_ALO = 2'b00,
        PH_AHI = 2'b01,
        PH_RD  = 2'b10,
        PH_WR  = 2'b11
    } phase_e;

    typedef struct packed {
        phase_e s1;
        phase_e s2;
    } sync_t;

    localparam logic [ADDR_W-1:0] WIN_LO = 16'hA000;
    localparam logic [ADDR_W-1:0] WIN_HI = 16'hA047;

    localparam logic [ADDR_W-1:0] PER_LO [N_PER] = '{16'hA000, 16'hA020, 16'hA030, 16'hA040};
    localparam logic [ADDR_W-1:0] PER_HI [N_PER] = '{16'hA00B, 16'hA027, 16'hA033, 16'hA047};
endpackage

// File: rtl/phase_sync.sv
module phase_sync
    import bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase_raw,
    output phase_e     phase
);
    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = phase_e'(phase_raw);
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{s1: PH_ALO, s2: PH_ALO};
        else        sync_q <= sync_d;
    end

    assign phase = sync_q.s2;
endmodule

// File: rtl/addr_decode.sv
module addr_decode
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              internal,
    output logic [N_PER-1:0]  sel
);
    assign internal = (addr >= WIN_LO) && (addr <= WIN_HI);

    for (genvar i = 0; i < N_PER; i++) begin : g_region
        assign sel[i] = (addr >= PER_LO[i]) && (addr <= PER_HI[i]);
    end

    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    assert_sel_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|sel) |-> internal);
endmodule

// File: rtl/pad_mux.sv
module pad_mux
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_wr,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe
);
    always_comb begin
        pad_out = '0;
        pad_oe  = 1'b0;
        unique case (phase)
            PH_AHI: begin pad_out = addr[ADDR_W-1 -: DATA_W]; pad_oe = 1'b1;   end
            PH_ALO: begin pad_out = addr[DATA_W-1:0];         pad_oe = 1'b1;   end
            PH_RD:  begin pad_out = '0;                       pad_oe = 1'b0;   end
            PH_WR:  begin pad_out = wdata;                    pad_oe = ext_wr; end
            default: ;
        endcase
    end

    assert_rd_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RD) |-> !pad_oe);
    assert_addr_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ALO) |-> pad_oe);
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
    import bridge_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             cpu_addr,
    input  logic [7:0]              cpu_wdata,
    input  logic                    cpu_rnw,
    output logic [7:0]              cpu_rdata,
    input  logic [1:0]              phase_sel,
    input  logic [7:0]              pad_in,
    output logic [7:0]              pad_out,
    output logic                    pad_oe,
    output logic                    ext_rnw,
    output logic                    ext_cycle,
    output logic [3:0]              per_sel,
    output logic                    per_wr,
    input  logic [31:0]             per_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } cap_t;

    phase_e phase;
    logic   internal;
    logic   ext_wr;
    logic [DATA_W-1:0] per_byte;
    cap_t   cap_d, cap_q;

    phase_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_raw (phase_sel),
        .phase     (phase)
    );

    addr_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .internal (internal),
        .sel      (per_sel)
    );

    assign ext_wr    = !cpu_rnw && !internal;
    assign ext_rnw   = cpu_rnw || internal;
    assign ext_cycle = !internal;
    assign per_wr    = !cpu_rnw && (|per_sel);

    pad_mux u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .addr    (cpu_addr),
        .wdata   (cpu_wdata),
        .ext_wr  (ext_wr),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    always_comb begin
        per_byte = '0;
        for (int i = 0; i < N_PER; i++) begin
            if (per_sel[i]) per_byte = per_byte | per_rdata[i*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        cap_d = cap_q;
        if (phase == PH_RD) cap_d.rdata = pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cpu_rdata = internal ? per_byte : cap_q.rdata;

    assert_addr_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_AHI) |-> (pad_oe && pad_out == cpu_addr[15:8]));
    assert_int_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_cycle && phase == PH_WR) |-> !pad_oe);
    assert_int_no_extwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cycle |-> ext_rnw);
    assert_perwr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |-> (!cpu_rnw && !ext_cycle && (|per_sel)));
    assert_cap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RD && ext_cycle && $stable(cpu_addr)) |=> (ext_cycle -> $stable(cpu_rdata)));
endmodule

// File: tb/sim_mux_bus_bridge.sv
module sim_mux_bus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h1234;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rnw = 1'b1;
    logic [7:0]  cpu_rdata;
    logic [1:0]  phase_sel = 2'b00;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic        pad_oe;
    logic        ext_rnw;
    logic        ext_cycle;
    logic [3:0]  per_sel;
    logic        per_wr;
    logic [31:0] per_rdata = 32'h44332211;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mux_bus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rnw(cpu_rnw), .cpu_rdata(cpu_rdata), .phase_sel(phase_sel),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .ext_rnw(ext_rnw),
        .ext_cycle(ext_cycle), .per_sel(per_sel), .per_wr(per_wr), .per_rdata(per_rdata)
    );

    // behavioural reference: delayed phase history and captured byte
    int m_s1 = 0, m_s2 = 0;
    int m_rd = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
        end else begin
            m_s1 <= int'(phase_sel);
            m_s2 <= m_s1;
            if (m_s2 == 2) m_rd <= int'(pad_in);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h phase %0d)",
                     req, act, exp, cpu_addr, m_s2);
        end
    endtask

    function automatic int exp_sel(input int a);
        if (a >= 'hA000 && a <= 'hA00B) return 1;
        if (a >= 'hA020 && a <= 'hA027) return 2;
        if (a >= 'hA030 && a <= 'hA033) return 4;
        if (a >= 'hA040 && a <= 'hA047) return 8;
        return 0;
    endfunction

    task automatic compare_all();
        int a = int'(cpu_addr);
        bit inw = (a >= 'hA000 && a <= 'hA047);
        int s = exp_sel(a);
        int oe, po, rd;
        case (m_s2)
            0: begin oe = 1; po = a & 'hFF; end
            1: begin oe = 1; po = a >> 8; end
            2: begin oe = 0; po = 0; end
            default: begin oe = (!cpu_rnw && !inw) ? 1 : 0; po = int'(cpu_wdata); end
        endcase
        if (!inw)       rd = m_rd;
        else if (s == 1) rd = int'(per_rdata[7:0]);
        else if (s == 2) rd = int'(per_rdata[15:8]);
        else if (s == 4) rd = int'(per_rdata[23:16]);
        else if (s == 8) rd = int'(per_rdata[31:24]);
        else            rd = 0;
        case (m_s2)
            0: begin chk("R2 oe", int'(pad_oe), oe); chk("R2 pad", int'(pad_out), po); end
            1: begin chk("R1 oe", int'(pad_oe), oe); chk("R1 pad", int'(pad_out), po); end
            2: chk("R3 oe", int'(pad_oe), oe);
            default: begin
                chk("R4 oe", int'(pad_oe), oe);
                if (oe == 1) chk("R4 pad", int'(pad_out), po);
            end
        endcase
        chk("R5 ext_rnw", int'(ext_rnw), (cpu_rnw || inw) ? 1 : 0);
        chk("R6 ext_cycle", int'(ext_cycle), inw ? 0 : 1);
        chk("R7 per_sel", int'(per_sel), s);
        chk(inw ? "R8 rdata" : "R3 rdata", int'(cpu_rdata), rd);
        chk("R9 per_wr", int'(per_wr), (!cpu_rnw && s != 0) ? 1 : 0);
    endtask

    function automatic logic [15:0] pick_addr(input int k);
        case (k)
            0: return 16'h9FFF;  1: return 16'hA000;  2: return 16'hA00B;
            3: return 16'hA00C;  4: return 16'hA00F;  5: return 16'hA010;
            6: return 16'hA017;  7: return 16'hA018;  8: return 16'hA020;
            9: return 16'hA027; 10: return 16'hA028; 11: return 16'hA030;
           12: return 16'hA033; 13: return 16'hA034; 14: return 16'hA040;
           15: return 16'hA047; 16: return 16'hA048; 17: return 16'hFFFF;
           18: return 16'h0000;
           19, 20: return 16'hA000 | 16'($urandom % 'h48);
           default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(7));
        // reset state
        #20;
        @(negedge clk);
        chk("R2 reset oe", int'(pad_oe), 1);
        chk("R2 reset pad", int'(pad_out), 'h34);
        chk("R3 reset rdata", int'(cpu_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: two-edge delay of the phase code
        phase_sel = 2'b10;
        @(negedge clk);
        chk("R10 one edge", int'(pad_oe), 1);
        @(negedge clk);
        chk("R10 two edges", int'(pad_oe), 0);
        // R3 capture then hold across other phases
        pad_in = 8'hC3;
        phase_sel = 2'b00;
        @(negedge clk);
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        chk("R3 captured", int'(cpu_rdata), 'hC3);
        @(negedge clk);
        chk("R3 held", int'(cpu_rdata), 'hC3);
        // R9 reserved write: no strobe, no external cycle
        cpu_addr = 16'hA012; cpu_rnw = 1'b0; cpu_wdata = 8'hEE; phase_sel = 2'b11;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R9 reserved wr", int'(per_wr), 0);
        chk("R9 reserved ext", int'(ext_cycle), 1'b0);
        chk("R4 reserved oe", int'(pad_oe), 0);
        chk("R8 reserved rd", int'(cpu_rdata), 0);
        // randomized traffic, compared cycle by cycle against the model
        for (int i = 0; i < 3000; i++) begin
            cpu_addr  = pick_addr(int'($urandom % 26));
            cpu_rnw   = 1'($urandom);
            cpu_wdata = 8'($urandom);
            pad_in    = 8'($urandom);
            per_rdata = $urandom;
            if (($urandom % 3) != 0) phase_sel = 2'($urandom);
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule